// File: doc/BRIEF.md
# Cipher Accelerator Control Register and Request Logic

This block holds the single control word of a block-cipher accelerator and turns it into the signals that the rest of the accelerator uses. A simple memory-mapped port writes and reads the word. The decoded fields go to the cipher core. The block also produces two DMA request lines and one interrupt line. The cipher datapath is not part of this block.

The word holds several fields: enable, operating mode, algorithm, key length, authenticated-mode phase, padding count, two DMA enables and two interrupt enables. The key-length field locks while the block is running. DMA requests are raised only in the two data-moving modes. Each request is tied to the core's own readiness for that direction and drops for one cycle after every acknowledged transfer. The interrupt combines three status flags with their enable bits.

Top module: `cacc_ctrl`

## Requirements
- R1: After reset every field is 0. `bus_rdata` reads 0, and `dma_in_req`, `dma_out_req` and `irq` are low.
- R2: A write with `bus_wr` high is captured on the same rising clock edge. While `bus_rd` is high, `bus_rdata` returns the fields at these bit positions: enable 0, mode 2:1, algorithm 5:3, completion interrupt enable 9, error interrupt enable 10, input DMA enable 11, output DMA enable 12, phase 14:13, key length 18, padding count 23:20. While `bus_rd` is low, `bus_rdata` is 0. The padding count (0 = no padding, N = N least-significant bytes padded) appears unchanged on `cr_pad`.
- R3: Bits 31:24, 19, 17, 16, 15 and 8:6 ignore writes and always read as 0.
- R4: A write whose bit 0 is 1 leaves the key-length bit (bit 18; 0 = 128-bit, 1 = 256-bit) unchanged when enable was already 1 before that write.
- R5: The key-length bit takes the written value when enable was 0 before the write, or when the write itself clears enable.
- R6: `cr_phase` (00 init, 01 header, 10 payload, 11 final) follows the stored phase only when the algorithm field is 3 or 4, which are the authenticated algorithms. For any other algorithm it is 00. The stored phase still reads back.
- R7: `dma_in_req` rises one clock after enable, input DMA enable, a mode field of 1 or 3, and `core_in_rdy` are all high. It falls one clock after `core_in_rdy` drops.
- R8: `dma_out_req` behaves the same way, using output DMA enable and `core_out_vld`.
- R9: A mode field of 0 or 2 (2 = key derivation) never produces a DMA request, even when the DMA enables are set and the core flags are high.
- R10: A request that is acknowledged in a cycle is low in the next cycle. It returns in the cycle after that if its conditions still hold.
- R11: `irq` is high when (`st_ccf` and completion enable) or ((`st_rderr` or `st_wrerr`) and error enable). It is combinational, so it follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| core_in_rdy | input | 1 | Core can accept input data |
| core_out_vld | input | 1 | Core has output data |
| dma_in_ack | input | 1 | Input transfer accepted |
| dma_out_ack | input | 1 | Output transfer accepted |
| st_ccf | input | 1 | Computation-complete flag |
| st_rderr | input | 1 | Read-error flag |
| st_wrerr | input | 1 | Write-error flag |
| cr_en | output | 1 | Enable |
| cr_mode | output | 2 | Operating mode |
| cr_alg | output | 3 | Algorithm select |
| cr_key256 | output | 1 | Key length, 1 = 256-bit |
| cr_phase | output | 2 | Effective phase |
| cr_pad | output | 4 | Padding byte count |
| dma_in_req | output | 1 | Input DMA request |
| dma_out_req | output | 1 | Output DMA request |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is the key-length lock. It depends on the enable value from before a write, so both halves of the rule need a write that changes enable and the key bit in the same cycle. The stimulus first sets enable and the key bit together. It then tries to change the key bit while keeping enable high, and finally changes the key bit in the same write that clears enable. The acknowledge gap is reached by holding the core flag high and pulsing the acknowledge for exactly one cycle while the request is up.

// File: rtl/cacc_pkg.sv
package cacc_pkg;
  localparam int CR_W   = 32;
  localparam int PAD_W  = 4;
  localparam int MODE_W = 2;
  localparam int ALG_W  = 3;
  localparam int PH_W   = 2;

  localparam int B_EN    = 0;
  localparam int B_MODE  = 1;
  localparam int B_ALG   = 3;
  localparam int B_CCFIE = 9;
  localparam int B_ERRIE = 10;
  localparam int B_DIN   = 11;
  localparam int B_DOUT  = 12;
  localparam int B_PH    = 13;
  localparam int B_KEY   = 18;
  localparam int B_PAD   = 20;

  typedef struct packed {
    logic [PAD_W-1:0]  pad;
    logic              key256;
    logic [PH_W-1:0]   phase;
    logic              dma_out_en;
    logic              dma_in_en;
    logic              err_ie;
    logic              ccf_ie;
    logic [ALG_W-1:0]  alg;
    logic [MODE_W-1:0] mode;
    logic              en;
  } cr_t;

  function automatic cr_t cr_unpack(input logic [CR_W-1:0] w);
    cr_t c;
    c.en         = w[B_EN];
    c.mode       = w[B_MODE +: MODE_W];
    c.alg        = w[B_ALG +: ALG_W];
    c.ccf_ie     = w[B_CCFIE];
    c.err_ie     = w[B_ERRIE];
    c.dma_in_en  = w[B_DIN];
    c.dma_out_en = w[B_DOUT];
    c.phase      = w[B_PH +: PH_W];
    c.key256     = w[B_KEY];
    c.pad        = w[B_PAD +: PAD_W];
    return c;
  endfunction

  function automatic logic [CR_W-1:0] cr_pack(input cr_t c);
    logic [CR_W-1:0] w;
    w = '0;
    w[B_EN]              = c.en;
    w[B_MODE +: MODE_W]  = c.mode;
    w[B_ALG +: ALG_W]    = c.alg;
    w[B_CCFIE]           = c.ccf_ie;
    w[B_ERRIE]           = c.err_ie;
    w[B_DIN]             = c.dma_in_en;
    w[B_DOUT]            = c.dma_out_en;
    w[B_PH +: PH_W]      = c.phase;
    w[B_KEY]             = c.key256;
    w[B_PAD +: PAD_W]    = c.pad;
    return w;
  endfunction

  function automatic logic alg_is_auth(input logic [ALG_W-1:0] a);
    return (a == ALG_W'(3)) || (a == ALG_W'(4));
  endfunction

  function automatic logic mode_moves_data(input logic [MODE_W-1:0] m);
    return (m == MODE_W'(1)) || (m == MODE_W'(3));
  endfunction

  function automatic logic irq_merge(input logic ccf, input logic ccf_ie,
                                     input logic rderr, input logic wrerr,
                                     input logic err_ie);
    return (ccf & ccf_ie) | ((rderr | wrerr) & err_ie);
  endfunction
endpackage

// File: rtl/cacc_regs.sv
module cacc_regs
  import cacc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CR_W-1:0] wdata,
  output cr_t             q,
  output logic            key_lock
);
  cr_t nx;
  logic unused_bits;

  assign unused_bits = ^{wdata[CR_W-1:B_PAD+PAD_W], wdata[B_KEY+1],
                         wdata[B_KEY-1:B_PH+PH_W], wdata[B_CCFIE-1:B_ALG+ALG_W]};

  // Key length frozen when running and this write keeps it running
  assign key_lock = wr & q.en & wdata[B_EN];

  always_comb begin
    nx = cr_unpack(wdata);
    if (key_lock) nx.key256 = q.key256;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= nx;
  end
endmodule

// File: rtl/cacc_dmareq.sv
module cacc_dmareq (
  input  logic clk,
  input  logic rst_n,
  input  logic permit,
  input  logic core_flag,
  input  logic ack,
  output logic req,
  output logic ack_hit
);
  assign ack_hit = req & ack;

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= permit & core_flag & ~ack_hit;
  end
endmodule

// File: rtl/cacc_irq.sv
module cacc_irq
  import cacc_pkg::*;
(
  input  cr_t  cr,
  input  logic st_ccf,
  input  logic st_rderr,
  input  logic st_wrerr,
  output logic irq
);
  assign irq = irq_merge(st_ccf, cr.ccf_ie, st_rderr, st_wrerr, cr.err_ie);
endmodule

// File: rtl/cacc_ctrl.sv
module cacc_ctrl
  import cacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [CR_W-1:0]  bus_wdata,
  input  logic             bus_rd,
  output logic [CR_W-1:0]  bus_rdata,
  input  logic             core_in_rdy,
  input  logic             core_out_vld,
  input  logic             dma_in_ack,
  input  logic             dma_out_ack,
  input  logic             st_ccf,
  input  logic             st_rderr,
  input  logic             st_wrerr,
  output logic             cr_en,
  output logic [MODE_W-1:0] cr_mode,
  output logic [ALG_W-1:0] cr_alg,
  output logic             cr_key256,
  output logic [PH_W-1:0]  cr_phase,
  output logic [PAD_W-1:0] cr_pad,
  output logic             dma_in_req,
  output logic             dma_out_req,
  output logic             irq
);
  localparam int NDIR = 2;

  cr_t  cr;
  logic key_lock;
  logic data_mode;
  logic [NDIR-1:0] d_en, d_flag, d_ack, d_req, d_hit, d_permit;

  cacc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
    .q(cr), .key_lock(key_lock)
  );

  assign data_mode = mode_moves_data(cr.mode);
  assign d_en   = {cr.dma_out_en, cr.dma_in_en};
  assign d_flag = {core_out_vld, core_in_rdy};
  assign d_ack  = {dma_out_ack, dma_in_ack};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign d_permit[d] = cr.en & d_en[d] & data_mode;
    cacc_dmareq u_req (
      .clk(clk), .rst_n(rst_n), .permit(d_permit[d]),
      .core_flag(d_flag[d]), .ack(d_ack[d]),
      .req(d_req[d]), .ack_hit(d_hit[d])
    );
  end

  cacc_irq u_irq (
    .cr(cr), .st_ccf(st_ccf), .st_rderr(st_rderr), .st_wrerr(st_wrerr), .irq(irq)
  );

  assign dma_in_req  = d_req[0];
  assign dma_out_req = d_req[1];
  assign bus_rdata   = bus_rd ? cr_pack(cr) : '0;
  assign cr_en       = cr.en;
  assign cr_mode     = cr.mode;
  assign cr_alg      = cr.alg;
  assign cr_key256   = cr.key256;
  assign cr_pad      = cr.pad;
  assign cr_phase    = alg_is_auth(cr.alg) ? cr.phase : '0;
endmodule

// File: rtl/cacc_ctrl_chk.sv
module cacc_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        cr_en,
  input logic [1:0]  cr_mode,
  input logic        cr_key256,
  input logic [3:0]  cr_pad,
  input logic        dma_in_req,
  input logic        dma_out_req,
  input logic        dma_in_ack,
  input logic        dma_out_ack,
  input logic        st_ccf,
  input logic        st_rderr,
  input logic        st_wrerr,
  input logic        irq,
  input logic        key_lock
);
  AST_KEY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cr_en && bus_wdata[0]) |=> $stable(cr_key256)); // R4
  AST_KEY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !key_lock) |=> (cr_key256 == $past(bus_wdata[18]))); // R5
  AST_PAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (cr_pad == $past(bus_wdata[23:20]))); // R2
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_rdata[19] == 1'b0 && bus_rdata[17] == 1'b0 && bus_rdata[15] == 1'b0)); // R3
  AST_NO_KDF_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(cr_mode) == 2'd1 || $past(cr_mode) == 2'd3) |-> !(dma_in_req || dma_out_req)); // R9
  AST_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_in_req && dma_in_ack) |=> !dma_in_req); // R10
  AST_OUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_out_req && dma_out_ack) |=> !dma_out_req); // R10
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_ccf || st_rderr || st_wrerr)); // R11
endmodule

bind cacc_ctrl cacc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cr_en(cr_en), .cr_mode(cr_mode),
  .cr_key256(cr_key256), .cr_pad(cr_pad), .dma_in_req(dma_in_req),
  .dma_out_req(dma_out_req), .dma_in_ack(dma_in_ack), .dma_out_ack(dma_out_ack),
  .st_ccf(st_ccf), .st_rderr(st_rderr), .st_wrerr(st_wrerr), .irq(irq),
  .key_lock(key_lock)
);

// File: tb/sim_cacc_ctrl.sv
module sim_cacc_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic core_in_rdy = 0, core_out_vld = 0, dma_in_ack = 0, dma_out_ack = 0;
  logic st_ccf = 0, st_rderr = 0, st_wrerr = 0;
  logic cr_en, cr_key256, dma_in_req, dma_out_req, irq;
  logic [1:0] cr_mode, cr_phase;
  logic [2:0] cr_alg;
  logic [3:0] cr_pad;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cacc_ctrl u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(output logic [31:0] v);
    bus_rd = 1; #1; v = bus_rdata; bus_rd = 0; #1;
  endtask

  function automatic logic [31:0] f(input int pos, input logic [31:0] val);
    return val << pos;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(v);
    chk_eq("R1 rdata", v, 0);
    chk_eq("R1 outs", {cr_en, cr_mode, cr_alg, cr_key256, cr_pad, dma_in_req, dma_out_req, irq}, 0);
  endtask

  task automatic t_rw();
    logic [31:0] v, w;
    w = f(1,2) | f(3,5) | f(9,1) | f(10,1) | f(11,1) | f(12,1) | f(13,3) | f(18,1) | f(20,4'hB);
    wr(w);
    rd(v);
    chk_eq("R2 readback", v, w);
    chk_eq("R2 pad", cr_pad, 4'hB);
    chk_eq("R2 rd low", bus_rdata, 0);
    wr(32'hFFFF_FFFF);
    rd(v);
    chk_eq("R3 reserved", v, 32'h00F4_7E3F);
    wr(0);
  endtask

  task automatic t_key();
    wr(f(0,1) | f(18,1));
    chk_eq("R5 key set en was 0", cr_key256, 1);
    wr(f(0,1));
    chk_eq("R4 key locked", cr_key256, 1);
    wr(0);
    chk_eq("R5 key cleared by en clear", cr_key256, 0);
    wr(f(0,1));
    wr(f(0,1) | f(18,1));
    chk_eq("R4 key locked set", cr_key256, 0);
    wr(0);
  endtask

  task automatic t_phase();
    logic [31:0] v;
    wr(f(3,3) | f(13,2));
    chk_eq("R6 auth alg3", cr_phase, 2);
    wr(f(3,4) | f(13,1));
    chk_eq("R6 auth alg4", cr_phase, 1);
    wr(f(3,1) | f(13,2));
    chk_eq("R6 non-auth", cr_phase, 0);
    rd(v);
    chk_eq("R6 stored", v[14:13], 2);
    wr(0);
  endtask

  task automatic t_dma_in();
    wr(f(0,1) | f(1,1) | f(11,1));
    core_in_rdy = 1;
    @(negedge clk);
    chk_eq("R7 in req", dma_in_req, 1);
    chk_eq("R8 out idle", dma_out_req, 0);
    dma_in_ack = 1;
    @(negedge clk);
    dma_in_ack = 0;
    chk_eq("R10 gap", dma_in_req, 0);
    @(negedge clk);
    chk_eq("R10 return", dma_in_req, 1);
    core_in_rdy = 0;
    @(negedge clk);
    chk_eq("R7 drop", dma_in_req, 0);
    wr(0);
  endtask

  task automatic t_dma_out();
    wr(f(0,1) | f(1,3) | f(12,1));
    core_out_vld = 1;
    @(negedge clk);
    chk_eq("R8 out req", dma_out_req, 1);
    dma_out_ack = 1;
    @(negedge clk);
    dma_out_ack = 0;
    chk_eq("R10 out gap", dma_out_req, 0);
    @(negedge clk);
    chk_eq("R8 out return", dma_out_req, 1);
    core_out_vld = 0;
    @(negedge clk);
    chk_eq("R8 drop", dma_out_req, 0);
    wr(0);
  endtask

  task automatic t_dma_mode();
    for (int m = 0; m < 4; m += 2) begin
      wr(f(0,1) | f(1,m) | f(11,1) | f(12,1));
      core_in_rdy = 1; core_out_vld = 1;
      @(negedge clk); @(negedge clk);
      chk_eq("R9 no req", {dma_in_req, dma_out_req}, 0);
      core_in_rdy = 0; core_out_vld = 0;
    end
    wr(0);
  endtask

  task automatic t_irq();
    wr(f(9,1));
    st_ccf = 1; #1;
    chk_eq("R11 ccf", irq, 1);
    st_ccf = 0; st_rderr = 1; #1;
    chk_eq("R11 err masked", irq, 0);
    wr(f(10,1));
    #1;
    chk_eq("R11 rderr", irq, 1);
    st_rderr = 0; st_wrerr = 1; #1;
    chk_eq("R11 wrerr", irq, 1);
    st_wrerr = 0; st_ccf = 1; #1;
    chk_eq("R11 ccf masked", irq, 0);
    st_ccf = 0;
    wr(0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_key();
    t_phase();
    t_dma_in();
    t_dma_out();
    t_dma_mode();
    t_irq();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule